// File: doc/BRIEF.md
# Decimal-Capable Accumulator Adder/Subtractor

This unit holds the accumulator and the two index registers of a small CPU with an 8/16-bit accumulator. It performs add-with-carry, subtract-with-borrow and register compare. A width input picks whether an operation works on the low byte or on the whole 16-bit word. A decimal input switches add and subtract from plain binary to packed BCD. In BCD mode each 4-bit digit is corrected in a ripple from the lowest digit upward.

The sequencer drives a one-cycle strobe together with an opcode, a register select, an operand word and the current carry and overflow bits. On the next clock edge the unit writes the affected register and the N, V, Z and C flags, and it raises a one-cycle done pulse. A load opcode writes the operand into A, X or Y, so that the registers can be set up before arithmetic.

Top module: `bcd_accum_alu`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) clears A, X, Y, the N, V, Z and C flags, and done.
- R2: Binary add (op_kind 00, dec_mode 0) gives A + operand + c_in in the active width. C is 1 when the full sum reaches 2^8 (narrow) or 2^16 (wide).
- R3: Binary subtract (op_kind 01, dec_mode 0) gives A − operand + c_in − 1 in the active width. C is 1 when that value is zero or more.
- R4: Decimal add (op_kind 00, dec_mode 1) adds digit by digit, with c_in going into the lowest digit only. A digit sum above 9 loses 10 and carries 1 into the next digit. C is the carry out of the top active digit (digit 1 when narrow, digit 3 when wide).
- R5: Decimal subtract (op_kind 01, dec_mode 1) subtracts digit by digit, and the lowest digit also subtracts the inverse of c_in. A digit that goes below 0 or above 9 gains 10 and borrows 1 from the next digit. C is 0 when the top active digit borrows and 1 otherwise.
- R6: For add, V is 1 when A and the operand share a sign bit and the stored result has the other sign. In decimal mode this uses the corrected result.
- R7: For subtract, V is 1 when the signs of A and the operand differ and the result's sign differs from A's.
- R8: Compare (op_kind 10) takes the register chosen by reg_sel (00 A, 01 X, 10 Y) minus the operand. It is always binary, whatever dec_mode says. C is 1 when register ≥ operand, N and Z come from the difference, V takes v_in, and no register changes.
- R9: With wide = 0 only the low byte of the target register is read and written, and its high byte keeps its value. N is bit 7 of the result when narrow and bit 15 when wide.
- R10: Z is 1 exactly when the result, masked to the active width, is zero.
- R11: Results and flags register on the clock edge where op_valid is high. done is high for the one cycle after it. Without a strobe, registers and flags do not change.
- R12: Load (op_kind 11) writes the operand to the register chosen by reg_sel (00 or 11 A, 01 X, 10 Y). N and Z are set from the loaded value, and C and V take c_in and v_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | One-cycle operation strobe |
| op_kind | input | 2 | 00 add, 01 subtract, 10 compare, 11 load |
| reg_sel | input | 2 | Register for compare/load: 00 A, 01 X, 10 Y, 11 A |
| operand | input | 16 | Operand word |
| wide | input | 1 | 1 = 16-bit, 0 = low byte |
| dec_mode | input | 1 | 1 = packed BCD add/subtract |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| acc_q | output | 16 | Accumulator |
| x_q | output | 16 | X index register |
| y_q | output | 16 | Y index register |
| n_q | output | 1 | Negative flag |
| v_q | output | 1 | Overflow flag |
| z_q | output | 1 | Zero flag |
| c_q | output | 1 | Carry flag |
| done_q | output | 1 | Result-valid pulse |

## Verification
Binary operations are driven with operands that wrap, that land exactly on zero and that cross the sign boundary. These separate the carry path from the overflow path. Decimal operations use digit sums that ripple through several digits, a carry-in that rolls 9999 over to 0000, and a borrow out of 0000. These show whether the digit chain passes its carry or borrow along correctly and where C is taken from. Compares run against A, X and Y, and also with dec_mode high, with an input overflow bit that must pass through, and in narrow mode where the high bytes differ. Together they expose a wrong source select, accidental decimal correction or a Z flag that is not width-masked.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_CMP  = 2'd2,
    OP_LOAD = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic [3:0] val;
    logic       link;
  } nib_res_t;

  // one BCD digit of an add: link is the carry into the next digit
  function automatic nib_res_t dec_add_nib(input logic [3:0] a, input logic [3:0] b,
                                           input logic cin);
    logic [4:0] s;
    nib_res_t   r;
    s = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (s > 5'd9) begin
      r.val  = s[3:0] - 4'd10;
      r.link = 1'b1;
    end else begin
      r.val  = s[3:0];
      r.link = 1'b0;
    end
    return r;
  endfunction

  // one BCD digit of a subtract: link is the borrow out of the digit
  function automatic nib_res_t dec_sub_nib(input logic [3:0] a, input logic [3:0] b,
                                           input logic bin);
    logic [4:0] t;
    nib_res_t   r;
    t = {1'b0, a} - {1'b0, b} - {4'b0, bin};
    if (t[4] || (t[3:0] > 4'd9)) begin
      r.val  = t[3:0] + 4'd10;
      r.link = 1'b1;
    end else begin
      r.val  = t[3:0];
      r.link = 1'b0;
    end
    return r;
  endfunction

  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sb);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/bcd_nibble_chain.sv
module bcd_nibble_chain
  import bcd_alu_pkg::*;
#(
  parameter int NIBBLES  = 4,
  parameter int LOW_NIB  = 2,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [4*NIBBLES-1:0] a_i,
  input  logic [4*NIBBLES-1:0] b_i,
  input  logic                 link_i,
  output logic [4*NIBBLES-1:0] res_o,
  output logic                 link_low_o,
  output logic                 link_full_o
);
  logic [NIBBLES:0] link;
  assign link[0] = link_i;

  for (genvar i = 0; i < NIBBLES; i++) begin : g_dig
    nib_res_t r;
    if (SUBTRACT) begin : g_sub
      assign r = dec_sub_nib(a_i[4*i +: 4], b_i[4*i +: 4], link[i]);
    end else begin : g_add
      assign r = dec_add_nib(a_i[4*i +: 4], b_i[4*i +: 4], link[i]);
    end
    assign res_o[4*i +: 4] = r.val;
    assign link[i+1]       = r.link;
  end

  assign link_low_o  = link[LOW_NIB];
  assign link_full_o = link[NIBBLES];
endmodule

// File: rtl/bin_addsub.sv
module bin_addsub #(
  parameter int W     = 16,
  parameter int LOW_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_low_o,
  output logic         cy_full_o
);
  logic [W-1:0]   b_eff;
  logic [W:0]     full;
  logic [LOW_W:0] low;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign low   = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};

  assign sum_o     = full[W-1:0];
  assign cy_full_o = full[W];
  assign cy_low_o  = low[LOW_W];
endmodule

// File: rtl/bcd_accum_alu.sv
module bcd_accum_alu
  import bcd_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] operand,
  input  logic          wide,
  input  logic          dec_mode,
  input  logic          c_in,
  input  logic          v_in,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic          n_q,
  output logic          v_q,
  output logic          z_q,
  output logic          c_q,
  output logic          done_q
);
  localparam int NIB  = DW / 4;
  localparam int LNIB = LW / 4;

  alu_op_e kind;
  assign kind = alu_op_e'(op_kind);

  logic is_cmp, is_load;
  assign is_cmp  = (kind == OP_CMP);
  assign is_load = (kind == OP_LOAD);

  // register picked by reg_sel (X, Y, otherwise A)
  logic [DW-1:0] sel_reg;
  always_comb begin
    case (reg_sel)
      2'd1:    sel_reg = x_q;
      2'd2:    sel_reg = y_q;
      default: sel_reg = acc_q;
    endcase
  end

  // binary path: compare uses the selected register with carry forced in
  logic [DW-1:0] bin_a, bin_sum;
  logic          bin_cy_low, bin_cy_full;
  assign bin_a = is_cmp ? sel_reg : acc_q;

  bin_addsub #(.W(DW), .LOW_W(LW)) u_bin (
    .a_i(bin_a), .b_i(operand), .cin_i(is_cmp | c_in), .sub_i(kind != OP_ADD),
    .sum_o(bin_sum), .cy_low_o(bin_cy_low), .cy_full_o(bin_cy_full)
  );

  // decimal paths
  logic [DW-1:0] dadd_res, dsub_res;
  logic          dadd_cy_low, dadd_cy_full, dsub_bo_low, dsub_bo_full;

  bcd_nibble_chain #(.NIBBLES(NIB), .LOW_NIB(LNIB), .SUBTRACT(1'b0)) u_dadd (
    .a_i(acc_q), .b_i(operand), .link_i(c_in),
    .res_o(dadd_res), .link_low_o(dadd_cy_low), .link_full_o(dadd_cy_full)
  );

  bcd_nibble_chain #(.NIBBLES(NIB), .LOW_NIB(LNIB), .SUBTRACT(1'b1)) u_dsub (
    .a_i(acc_q), .b_i(operand), .link_i(~c_in),
    .res_o(dsub_res), .link_low_o(dsub_bo_low), .link_full_o(dsub_bo_full)
  );

  // result and carry selection
  logic [DW-1:0] res;
  logic          res_cy;
  always_comb begin
    res    = bin_sum;
    res_cy = wide ? bin_cy_full : bin_cy_low;
    if (is_load) begin
      res    = operand;
      res_cy = c_in;
    end else if (dec_mode && kind == OP_ADD) begin
      res    = dadd_res;
      res_cy = wide ? dadd_cy_full : dadd_cy_low;
    end else if (dec_mode && kind == OP_SUB) begin
      res    = dsub_res;
      res_cy = wide ? ~dsub_bo_full : ~dsub_bo_low;
    end
  end

  // sign bits of the active width, named for the checker
  logic sign_a, sign_b, sign_r;
  assign sign_a = wide ? bin_a[DW-1]   : bin_a[LW-1];
  assign sign_b = wide ? operand[DW-1] : operand[LW-1];
  assign sign_r = wide ? res[DW-1]     : res[LW-1];

  logic res_v;
  always_comb begin
    case (kind)
      OP_ADD:  res_v = add_ovf(sign_a, sign_b, sign_r);
      OP_SUB:  res_v = sub_ovf(sign_a, sign_b, sign_r);
      default: res_v = v_in;
    endcase
  end

  logic res_zero;
  assign res_zero = wide ? (res == '0) : (res[LW-1:0] == '0);

  // width merge: narrow writes keep the target's high byte
  logic [DW-1:0] tgt_old, wr_val;
  assign tgt_old = is_load ? sel_reg : acc_q;
  assign wr_val  = wide ? res : {tgt_old[DW-1:LW], res[LW-1:0]};

  logic acc_we, x_we, y_we;
  assign acc_we = op_valid && ((kind == OP_ADD) || (kind == OP_SUB) ||
                               (is_load && reg_sel != 2'd1 && reg_sel != 2'd2));
  assign x_we   = op_valid && is_load && reg_sel == 2'd1;
  assign y_we   = op_valid && is_load && reg_sel == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      n_q    <= 1'b0;
      v_q    <= 1'b0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= op_valid;
      if (acc_we) acc_q <= wr_val;
      if (x_we)   x_q   <= wr_val;
      if (y_we)   y_q   <= wr_val;
      if (op_valid) begin
        n_q <= sign_r;
        v_q <= res_v;
        z_q <= res_zero;
        c_q <= res_cy;
      end
    end
  end
endmodule

// File: rtl/bcd_accum_alu_chk.sv
module bcd_accum_alu_chk #(
  parameter int DW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic          wide,
  input logic          v_in,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] y_q,
  input logic          n_q,
  input logic          v_q,
  input logic          z_q,
  input logic          c_q,
  input logic          done_q,
  input logic          acc_we
);
  AST_DONE_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done_q); // R11

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!done_q && $stable(acc_q) && $stable(x_q) && $stable(y_q) &&
                   $stable({n_q, v_q, z_q, c_q}))); // R11

  AST_ACC_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(acc_q)); // R8

  AST_CMP_PASSES_V: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2) |=> (v_q == $past(v_in))); // R8

  AST_NARROW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wide) |=> (acc_q[DW-1:LW] == $past(acc_q[DW-1:LW]))); // R9

  AST_Z_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1] == 1'b0) |=>
      (z_q == ($past(wide) ? (acc_q == '0) : (acc_q[LW-1:0] == '0)))); // R10

  AST_N_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1] == 1'b0) |=>
      (n_q == ($past(wide) ? acc_q[DW-1] : acc_q[LW-1]))); // R9
endmodule

bind bcd_accum_alu bcd_accum_alu_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .wide(wide),
  .v_in(v_in), .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .n_q(n_q), .v_q(v_q),
  .z_q(z_q), .c_q(c_q), .done_q(done_q), .acc_we(acc_we)
);

// File: tb/bcd_accum_alu_test.sv
module bcd_accum_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] operand = 16'h0;
  logic        wide = 1'b1, dec_mode = 1'b0, c_in = 1'b0, v_in = 1'b0;
  logic [15:0] acc_q, x_q, y_q;
  logic        n_q, v_q, z_q, c_q, done_q;

  always #10 clk = ~clk;

  bcd_accum_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .reg_sel(reg_sel),
    .operand(operand), .wide(wide), .dec_mode(dec_mode), .c_in(c_in), .v_in(v_in),
    .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .n_q(n_q), .v_q(v_q), .z_q(z_q), .c_q(c_q),
    .done_q(done_q)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] a, x, y;
    logic n, v, z, c;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  logic [15:0] sa = 0, sx = 0, sy = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int bcd2int(input logic [15:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'((v >> (4 * i)) & 16'hF);
    return r;
  endfunction

  function automatic logic [15:0] int2bcd(input int v, input int nd);
    logic [15:0] r = 0;
    int t = v;
    for (int i = 0; i < nd; i++) begin
      r = r | (16'(t % 10) << (4 * i));
      t = t / 10;
    end
    return r;
  endfunction

  task automatic issue(input logic [1:0] k, input logic [1:0] sel, input logic [15:0] opnd,
                       input logic w, input logic d, input logic ci, input logic vi,
                       input string tag);
    int mask, msb, nd, modv, av, bv, t, r;
    logic [15:0] regv;
    logic c, v;
    exp_t e;
    mask = w ? 32'hFFFF : 32'hFF;
    msb  = w ? 15 : 7;
    nd   = w ? 4 : 2;
    modv = w ? 10000 : 100;
    regv = (sel == 2'd1) ? sx : (sel == 2'd2) ? sy : sa;
    bv   = int'(opnd) & mask;
    av   = int'(sa) & mask;
    c = ci; v = vi; r = 0;
    case (k)
      2'd0: begin
        if (d) begin
          t = bcd2int(16'(av), nd) + bcd2int(16'(bv), nd) + int'(ci);
          c = (t >= modv);
          r = int'(int2bcd(t % modv, nd));
        end else begin
          t = av + bv + int'(ci);
          c = (t > mask);
          r = t & mask;
        end
        v = (((av >> msb) & 1) == ((bv >> msb) & 1)) && (((r >> msb) & 1) != ((bv >> msb) & 1));
      end
      2'd1: begin
        if (d) begin
          t = bcd2int(16'(av), nd) - bcd2int(16'(bv), nd) - (1 - int'(ci));
          c = (t >= 0);
          if (t < 0) t = t + modv;
          r = int'(int2bcd(t, nd));
        end else begin
          t = av - bv + int'(ci) - 1;
          c = (t >= 0);
          r = t & mask;
        end
        v = (((av >> msb) & 1) != ((bv >> msb) & 1)) && (((r >> msb) & 1) != ((av >> msb) & 1));
      end
      2'd2: begin
        t = (int'(regv) & mask) - bv;
        c = (t >= 0);
        r = t & mask;
      end
      default: r = bv;
    endcase
    e.n = 1'((r >> msb) & 1);
    e.z = (r == 0);
    e.c = c;
    e.v = v;
    if (k == 2'd0 || k == 2'd1 || (k == 2'd3 && sel != 2'd1 && sel != 2'd2))
      sa = (sa & ~16'(mask)) | 16'(r);
    else if (k == 2'd3 && sel == 2'd1) sx = (sx & ~16'(mask)) | 16'(r);
    else if (k == 2'd3 && sel == 2'd2) sy = (sy & ~16'(mask)) | 16'(r);
    e.a = sa; e.x = sx; e.y = sy; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; reg_sel = sel; operand = opnd;
    wide = w; dec_mode = d; c_in = ci; v_in = vi;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (rst_n && done_q) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(acc_q == e.a, e.tag, "A", acc_q, e.a);
        chk(x_q == e.x, e.tag, "X", x_q, e.x);
        chk(y_q == e.y, e.tag, "Y", y_q, e.y);
        chk(n_q == e.n, e.tag, "N", n_q, e.n);
        chk(v_q == e.v, e.tag, "V", v_q, e.v);
        chk(z_q == e.z, e.tag, "Z", z_q, e.z);
        chk(c_q == e.c, e.tag, "C", c_q, e.c);
      end
    end
  end

  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, CMP = 2'd2, LD = 2'd3;
  localparam logic [1:0] SA = 2'd0, SX = 2'd1, SY = 2'd2;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_q == 0 && x_q == 0 && y_q == 0, "R1", "regs after reset", acc_q | x_q | y_q, 0);
    chk({n_q, v_q, z_q, c_q, done_q} == 5'b0, "R1", "flags after reset",
        {n_q, v_q, z_q, c_q, done_q}, 0);
    rst_n = 1'b1;

    issue(LD,  SA, 16'h1234, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'h4321, 1, 0, 0, 0, "R2");
    issue(LD,  SA, 16'hFFFF, 1, 0, 1, 1, "R12");
    issue(ADD, SA, 16'h0001, 1, 0, 0, 0, "R2_R10");
    issue(LD,  SA, 16'h7FFF, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'h0001, 1, 0, 0, 0, "R6");
    issue(LD,  SA, 16'h12F0, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'hAA20, 0, 0, 0, 0, "R9");
    issue(LD,  SA, 16'h5000, 1, 0, 0, 0, "R12");
    issue(SUB, SA, 16'h1000, 1, 0, 1, 0, "R3");
    issue(SUB, SA, 16'h1000, 1, 0, 0, 0, "R3");
    issue(LD,  SA, 16'h1000, 1, 0, 0, 0, "R12");
    issue(SUB, SA, 16'h2000, 1, 0, 1, 0, "R3");
    issue(LD,  SA, 16'h8000, 1, 0, 0, 0, "R12");
    issue(SUB, SA, 16'h0001, 1, 0, 1, 0, "R7");
    issue(LD,  SA, 16'h0058, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'h0046, 0, 1, 0, 0, "R4");
    issue(LD,  SA, 16'h1999, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'h0001, 1, 1, 0, 0, "R4");
    issue(ADD, SA, 16'h7999, 1, 1, 1, 0, "R4_R10");
    issue(LD,  SA, 16'h0050, 1, 0, 0, 0, "R12");
    issue(ADD, SA, 16'h0030, 0, 1, 0, 0, "R6");
    issue(LD,  SA, 16'h0000, 1, 0, 0, 0, "R12");
    issue(SUB, SA, 16'h0001, 1, 1, 1, 0, "R5");
    issue(LD,  SA, 16'h0050, 1, 0, 0, 0, "R12");
    issue(SUB, SA, 16'h0025, 0, 1, 1, 0, "R5");
    issue(SUB, SA, 16'h0025, 0, 1, 0, 0, "R5");
    issue(LD,  SX, 16'h0040, 1, 0, 0, 0, "R12");
    issue(CMP, SX, 16'h0040, 1, 0, 0, 0, "R8");
    issue(CMP, SY, 16'h0001, 1, 0, 0, 1, "R8");
    issue(LD,  SA, 16'h0010, 1, 0, 0, 0, "R12");
    issue(CMP, SA, 16'h0009, 1, 1, 0, 0, "R8");
    issue(LD,  SA, 16'h1234, 1, 0, 0, 0, "R12");
    issue(CMP, SA, 16'h5634, 0, 0, 0, 0, "R10");
    issue(LD,  SY, 16'h77AB, 0, 0, 0, 0, "R9_R12");

    // R11: no strobe, nothing changes and done stays low
    @(negedge clk);
    begin
      logic [15:0] a0;
      logic [3:0] f0;
      a0 = acc_q; f0 = {n_q, v_q, z_q, c_q};
      repeat (5) @(negedge clk);
      chk(acc_q == a0, "R11", "A held while idle", acc_q, a0);
      chk({n_q, v_q, z_q, c_q} == f0, "R11", "flags held while idle",
          {n_q, v_q, z_q, c_q}, f0);
      chk(done_q == 1'b0, "R11", "done low while idle", done_q, 0);
    end
    chk(sb_q.size() == 0, "R11", "results outstanding", sb_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R11 watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule